// File: doc/BRIEF.md
# Secondary-Bus Parity Error Reporter

This block gathers the parity error events that a bus bridge sees on its secondary (downstream) PCI bus and turns them into three sticky status bits. It also raises an internal system-error pulse when the configured enable bits allow it. The event strobes come from the bus engine: a data parity error the bridge detected itself, PERR# sampled active by the bridge while it masters a write, and an address/command parity error. Each strobe is qualified by whether the bridge currently owns the bus and by the direction of its transfer.

The block also handles poisoned data arriving from the upstream link. From the first data phase that carries the upstream bad-parity mark until the end of that transaction, it drives a parity-invert control. The bus engine uses that control to corrupt the parity it generates, so the error is passed on downstream and not hidden. Software clears the status bits by writing ones to their positions. Reset is asserted asynchronously and released through a synchronizer inside the block.

Top module: `brg_parity_ctl`

## Requirements
- R1: Status bit 0 (detected parity error) is set whenever `ev_data_pe_i` or `ev_addr_pe_i` is high, whatever the enable bits and master state are. `ev_perr_i` alone does not set it.
- R2: Status bit 1 (data parity detected) is set when `mst_act_i` and `per_en_i` are high and either `ev_data_pe_i` is high with `mst_wr_i`=0 (read) or `ev_perr_i` is high with `mst_wr_i`=1 (write).
- R3: With `mst_act_i`=0 or `per_en_i`=0, data parity events never set status bit 1 and never pulse `serr_o`, although bit 0 is still set as in R1.
- R4: Status bit 2 (signaled system error) is set by `ev_addr_pe_i` only when `cmd_see_i`, `per_en_i` and `brg_see_i` are all high.
- R5: `serr_o` is high for exactly the one cycle after each cycle in which an R2 or R4 condition holds. Two conditions in the same cycle give one pulse. In all other cycles it is low.
- R6: A cycle with `sts_wr_i`=1 clears each status bit whose `sts_wdata_i` bit is 1 and leaves bits written with 0 unchanged. A set condition in the same cycle wins over the clear.
- R7: While reset is active, and for the synchronizer stages after its release, all status bits and `serr_o` are 0.
- R8: `par_inv_o` is high in any cycle where `dphase_i` and `up_poison_i` are both high. It stays high from that cycle through the cycle in which `xfer_end_i` is high, and drops in the cycle after.
- R9: A status bit set by an event is visible on `sts_o` in the clock cycle after the event cycle and stays set until cleared as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_act_i | input | 1 | Bridge currently masters the secondary bus |
| mst_wr_i | input | 1 | Direction of the mastered transfer: 1 write, 0 read |
| ev_data_pe_i | input | 1 | Data parity error detected by the bridge |
| ev_perr_i | input | 1 | PERR# sampled active |
| ev_addr_pe_i | input | 1 | Address/command parity error detected |
| per_en_i | input | 1 | Parity error response enable |
| brg_see_i | input | 1 | Bridge-level system-error enable |
| cmd_see_i | input | 1 | Command-register system-error enable |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 3 | Write-one-to-clear mask for the status bits |
| dphase_i | input | 1 | Forwarded data phase in this cycle |
| up_poison_i | input | 1 | Upstream data of this phase carries bad parity |
| xfer_end_i | input | 1 | Last cycle of the forwarded transaction |
| sts_o | output | 3 | Status: bit 0 detected, bit 1 data parity detected, bit 2 system error signaled |
| serr_o | output | 1 | Internal system-error pulse |
| par_inv_o | output | 1 | Force bad parity on the forwarded data |

## Verification
Directed sequences first hit each event with every enable bit dropped in turn. This shows that the gating of bit 1, bit 2 and the pulse is separate from the unconditional bit 0. Other directed cases put a read error and an address error in the same cycle to confirm a single pulse. They also compare write-one against write-zero, and a clear against a same-cycle set. Poison runs vary where the poisoned phase falls relative to clean phases and to the transaction end, including both in one cycle. A long stretch of seeded random events, enables, clears and data phases then checks every output in every cycle against a bench model.

// File: rtl/brg_par_pkg.sv
package brg_par_pkg;
  localparam int STS_W   = 3;
  localparam int STS_DET = 0;
  localparam int STS_DPD = 1;
  localparam int STS_SSE = 2;

  typedef struct packed {
    logic sse;
    logic dpd;
    logic det;
  } par_cond_t;
endpackage

// File: rtl/brg_par_rstsync.sv
module brg_par_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/brg_par_event.sv
module brg_par_event
  import brg_par_pkg::*;
(
  input  logic      mst_act_i,
  input  logic      mst_wr_i,
  input  logic      ev_data_pe_i,
  input  logic      ev_perr_i,
  input  logic      ev_addr_pe_i,
  input  logic      per_en_i,
  input  logic      brg_see_i,
  input  logic      cmd_see_i,
  output par_cond_t cond_o,
  output logic      serr_req_o
);
  logic rd_err;
  logic wr_err;
  logic master_fault;

  always_comb begin
    rd_err       = ev_data_pe_i & ~mst_wr_i;
    wr_err       = ev_perr_i & mst_wr_i;
    master_fault = mst_act_i & per_en_i & (rd_err | wr_err);
    cond_o.det   = ev_data_pe_i | ev_addr_pe_i;
    cond_o.dpd   = master_fault;
    cond_o.sse   = ev_addr_pe_i & cmd_see_i & per_en_i & brg_see_i;
    serr_req_o   = cond_o.dpd | cond_o.sse;
  end
endmodule

// File: rtl/brg_par_status.sv
module brg_par_status #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic clr;
    logic en;
    logic nxt;

    always_comb begin
      clr = wr_i & wdata_i[i];
      en  = set_i[i] | clr;
      nxt = set_i[i] | (sts_q[i] & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sts_q[i] <= 1'b0;
      else if (en) sts_q[i] <= nxt;
    end

    // R6
    w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[i] && !(wr_i && wdata_i[i])) |=> sts_q[i]);
    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i[i] && !set_i[i]) |=> !sts_q[i]);
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/brg_par_serr.sv
module brg_par_serr (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic serr_o
);
  logic serr_q;
  logic serr_d;

  always_comb serr_d = req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_q <= 1'b0;
    else        serr_q <= serr_d;
  end

  assign serr_o = serr_q;

  // R5
  serr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !serr_o);
endmodule

// File: rtl/brg_par_poison.sv
module brg_par_poison (
  input  logic clk,
  input  logic rst_n,
  input  logic dphase_i,
  input  logic up_poison_i,
  input  logic xfer_end_i,
  output logic par_inv_o
);
  logic hit;
  logic poison_q;
  logic poison_d;
  logic poison_en;

  always_comb begin
    hit       = dphase_i & up_poison_i;
    poison_en = hit | xfer_end_i;
    poison_d  = ~xfer_end_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         poison_q <= 1'b0;
    else if (poison_en) poison_q <= poison_d;
  end

  assign par_inv_o = poison_q | hit;

  // R8
  poison_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_inv_o && !xfer_end_i) |=> par_inv_o);
  // R8
  poison_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end_i |=> (par_inv_o == (dphase_i && up_poison_i)));
endmodule

// File: rtl/brg_parity_ctl.sv
module brg_parity_ctl
  import brg_par_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mst_act_i,
  input  logic             mst_wr_i,
  input  logic             ev_data_pe_i,
  input  logic             ev_perr_i,
  input  logic             ev_addr_pe_i,
  input  logic             per_en_i,
  input  logic             brg_see_i,
  input  logic             cmd_see_i,
  input  logic             sts_wr_i,
  input  logic [STS_W-1:0] sts_wdata_i,
  input  logic             dphase_i,
  input  logic             up_poison_i,
  input  logic             xfer_end_i,
  output logic [STS_W-1:0] sts_o,
  output logic             serr_o,
  output logic             par_inv_o
);
  logic       rst_int_n;
  par_cond_t  cond;
  logic       serr_req;

  brg_par_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  brg_par_event u_evt (
    .mst_act_i(mst_act_i), .mst_wr_i(mst_wr_i), .ev_data_pe_i(ev_data_pe_i),
    .ev_perr_i(ev_perr_i), .ev_addr_pe_i(ev_addr_pe_i), .per_en_i(per_en_i),
    .brg_see_i(brg_see_i), .cmd_see_i(cmd_see_i),
    .cond_o(cond), .serr_req_o(serr_req)
  );

  brg_par_status #(.W(STS_W)) u_sts (
    .clk(clk), .rst_n(rst_int_n), .set_i(cond), .wr_i(sts_wr_i),
    .wdata_i(sts_wdata_i), .sts_o(sts_o)
  );

  brg_par_serr u_serr (
    .clk(clk), .rst_n(rst_int_n), .req_i(serr_req), .serr_o(serr_o)
  );

  brg_par_poison u_poi (
    .clk(clk), .rst_n(rst_int_n), .dphase_i(dphase_i),
    .up_poison_i(up_poison_i), .xfer_end_i(xfer_end_i), .par_inv_o(par_inv_o)
  );

  // R1
  det_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ev_data_pe_i || ev_addr_pe_i) |=> sts_o[STS_DET]);
  // R3
  dpd_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mst_act_i || !per_en_i) |=> (sts_o[STS_DPD] == $past(sts_o[STS_DPD]) || !sts_o[STS_DPD]));
  // R4
  sse_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sts_o[STS_SSE]) |-> $past(ev_addr_pe_i && cmd_see_i && per_en_i && brg_see_i));
  // R5
  serr_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    serr_o |-> (sts_o[STS_DPD] || sts_o[STS_SSE]));
  // R7
  rst_clear_chk: assert property (@(posedge clk)
    !rst_int_n |-> (sts_o == '0 && !serr_o));
endmodule

// File: tb/brg_parity_ctl_tb.sv
module brg_parity_ctl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic m, w, dpe, perr, ape, per, bsee, csee, swr, dph, poi, xend;
  logic [2:0] swd;
  logic [2:0] sts;
  logic serr, pinv;

  int checks = 0;
  int errors = 0;

  logic [2:0] m_sts;
  logic m_serr;
  logic m_pois;

  always #5 clk = ~clk;

  brg_parity_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .mst_act_i(m), .mst_wr_i(w),
    .ev_data_pe_i(dpe), .ev_perr_i(perr), .ev_addr_pe_i(ape),
    .per_en_i(per), .brg_see_i(bsee), .cmd_see_i(csee),
    .sts_wr_i(swr), .sts_wdata_i(swd), .dphase_i(dph),
    .up_poison_i(poi), .xfer_end_i(xend),
    .sts_o(sts), .serr_o(serr), .par_inv_o(pinv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] f_set(input logic im, iw, idpe, iperr, iape, iper, ibsee, icsee);
    logic dpd_c, sse_c, det_c;
    det_c = idpe | iape;
    dpd_c = im & iper & ((idpe & ~iw) | (iperr & iw));
    sse_c = iape & icsee & iper & ibsee;
    return {sse_c, dpd_c, det_c};
  endfunction

  task automatic cyc(input logic im, iw, idpe, iperr, iape, iper, ibsee, icsee,
                     input logic iswr, input logic [2:0] iswd,
                     input logic idph, ipoi, ixend, input string tag);
    logic [2:0] s;
    m = im; w = iw; dpe = idpe; perr = iperr; ape = iape; per = iper;
    bsee = ibsee; csee = icsee; swr = iswr; swd = iswd;
    dph = idph; poi = ipoi; xend = ixend;
    #1;
    chk({"R8 par_inv ", tag}, {31'd0, pinv}, {31'd0, m_pois | (idph & ipoi)});
    s = f_set(im, iw, idpe, iperr, iape, iper, ibsee, icsee);
    m_serr = s[1] | s[2];
    m_sts  = s | (m_sts & ~(iswr ? iswd : 3'b000));
    m_pois = ixend ? 1'b0 : (m_pois | (idph & ipoi));
    @(posedge clk);
    @(negedge clk);
    chk({"R9 sts ", tag}, {29'd0, sts}, {29'd0, m_sts});
    chk({"R5 serr ", tag}, {31'd0, serr}, {31'd0, m_serr});
  endtask

  task automatic idle(input string tag);
    cyc(0,0,0,0,0,0,0,0, 0,3'b000, 0,0,0, tag);
  endtask

  task automatic clr_all(input string tag);
    cyc(0,0,0,0,0,0,0,0, 1,3'b111, 0,0,0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_sts = 3'b000; m_serr = 1'b0; m_pois = 1'b0;
    {m, w, dpe, perr, ape, per, bsee, csee, swr, dph, poi, xend} = '0;
    swd = 3'b000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 reset sts", {29'd0, sts}, 32'd0);
    chk("R7 reset serr", {31'd0, serr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 sync release sts", {29'd0, sts}, 32'd0);
    repeat (3) @(negedge clk);

    // R3: not master, and response disabled
    cyc(0,0,1,0,0,1,1,1, 0,3'b000, 0,0,0, "R3 not master");
    clr_all("R3 clear");
    cyc(1,0,1,0,0,0,1,1, 0,3'b000, 0,0,0, "R3 per off");
    clr_all("R3 clear2");
    // R2 read and write
    cyc(1,0,1,0,0,1,0,0, 0,3'b000, 0,0,0, "R2 read dpe");
    idle("R5 pulse ends");
    clr_all("R2 clear");
    cyc(1,1,0,1,0,1,0,0, 0,3'b000, 0,0,0, "R2 write perr R1 no det");
    clr_all("R2 clear2");
    cyc(1,1,1,0,0,1,0,0, 0,3'b000, 0,0,0, "R2 write dpe no dpd");
    clr_all("R2 clear3");
    // R4: each enable missing, then all
    cyc(0,0,0,0,1,0,1,1, 0,3'b000, 0,0,0, "R4 per off");
    cyc(0,0,0,0,1,1,0,1, 0,3'b000, 0,0,0, "R4 bsee off");
    cyc(0,0,0,0,1,1,1,0, 0,3'b000, 0,0,0, "R4 csee off");
    chk("R4 no sse", {31'd0, sts[2]}, 32'd0);
    cyc(0,0,0,0,1,1,1,1, 0,3'b000, 0,0,0, "R4 all on");
    clr_all("R4 clear");
    // R5 simultaneous
    cyc(1,0,1,0,1,1,1,1, 0,3'b000, 0,0,0, "R5 simultaneous");
    idle("R5 single pulse");
    // R6 write-zero, partial clear, set vs clear
    cyc(0,0,0,0,0,0,0,0, 1,3'b000, 0,0,0, "R6 write zero");
    cyc(0,0,0,0,0,0,0,0, 1,3'b010, 0,0,0, "R6 clear bit1");
    cyc(0,0,1,0,0,0,0,0, 1,3'b001, 0,0,0, "R6 set wins");
    chk("R6 set wins det", {31'd0, sts[0]}, 32'd1);
    clr_all("R6 clear");
    // R8 poison
    cyc(0,0,0,0,0,0,0,0, 0,3'b000, 1,0,0, "clean phase");
    cyc(0,0,0,0,0,0,0,0, 0,3'b000, 1,1,0, "first poison");
    cyc(0,0,0,0,0,0,0,0, 0,3'b000, 0,0,0, "gap");
    cyc(0,0,0,0,0,0,0,0, 1,3'b000, 1,0,0, "later clean phase");
    cyc(0,0,0,0,0,0,0,0, 0,3'b000, 0,0,1, "end");
    cyc(0,0,0,0,0,0,0,0, 0,3'b000, 1,0,0, "after end");
    cyc(0,0,0,0,0,0,0,0, 0,3'b000, 1,1,1, "poison at end");
    cyc(0,0,0,0,0,0,0,0, 0,3'b000, 1,0,0, "after poison end");

    // random: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[1], (r[4:2] == 3'd0), (r[7:5] == 3'd0), (r[10:8] == 3'd0),
          r[11] | r[12], r[13] | r[14], r[15] | r[16],
          (r[19:18] == 2'd0), r[22:20], r[23], (r[26:24] == 3'd0),
          (r[29:27] == 3'd0), "random R1_R2_R4_R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule